// File: doc/BRIEF.md
# Pin-Strapped I2C Output-Mask Register

This block is an I2C target that holds a single 8-bit register. Each bit of the register disables one of eight outputs elsewhere on the chip; a cleared bit leaves that output enabled. A bus master changes the mask with a two-byte write and fetches it with a two-byte read. The address byte is followed directly by the data byte, with no register pointer between them.

The seven-bit bus address has five fixed upper bits. Its two low bits come from strap inputs, so up to four copies can share one bus. SCL and SDA are oversampled by a much faster system clock. The open-drain SDA output is modelled as a pull-low enable: the pad drives low when the enable is high and floats otherwise. The pace of every transfer is set by the master's SCL, and the target never stretches the clock. The block therefore has no stream interface and no back-pressure: every pin is a plain level.

Top module: `i2c_oe_mask_slave`

## Requirements
- R1: After reset the mask output is 0x00 and the SDA pull-low enable is inactive.
- R2: The address byte is received bit 7 first and matches when it reads 1,1,0,1,0,strap[1],strap[0] followed by the direction bit (0 = write, 1 = read). On a match the target pulls SDA low from the SCL fall that ends the eighth bit until the next SCL fall.
- R3: After a write address, the next byte is taken bit 7 first, with bit 7 controlling output 7 and bit 0 controlling output 0. The mask takes the new value in the same clock that the eighth bit is sampled, and not before. The byte is acknowledged.
- R4: After a read address, the target presents the mask bit 7 first, changing its bit after each SCL fall. It pulls SDA low for a 0 bit and releases SDA for a 1 bit. It releases SDA during the master's acknowledge bit.
- R5: After an address that does not match, the target never pulls SDA low and the mask does not change until the next START or STOP.
- R6: A START, whether a first or a repeated one, is accepted in any state and restarts address reception. Any partial byte is discarded.
- R7: A STOP releases SDA and returns the target to idle. A write data byte cut short by a STOP leaves the mask unchanged.
- R8: Only one data byte is accepted per write. Further bytes are not acknowledged and do not change the mask.
- R9: The SDA pull-low enable changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| strap_i | input | 2 | Low two address bits, from strap pins |
| mask_o | output | 8 | Output-disable mask; bit n disables output n |
| sda_low_o | output | 1 | When high, the pad pulls SDA low |

## Verification
The hardest situations to reach are a repeated START that arrives partway through a byte and a STOP that cuts a write short. In both cases the partial shift state must be thrown away while the mask keeps its value. The bench's bus master can stop after any number of bits and then issue a repeated START or a STOP from SCL low. Each case is followed by a complete transfer or a read-back through the bus, so the mask is observed at the port. The bench also runs its own bit-level reference model against the bus lines, which include the target's own pull-down. Every clock it compares the mask and the SDA enable with that model, so a change of SDA that comes one clock early or late is caught.

// File: rtl/i2c_oe_pkg.sv
package i2c_oe_pkg;

  localparam int DATA_W   = 8;
  localparam int STRAP_W  = 2;
  localparam int FIXED_W  = 7 - STRAP_W;
  localparam logic [FIXED_W-1:0] ADDR_FIXED = 5'b11010;
  localparam int CNT_W    = $clog2(DATA_W + 1);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_AACK,
    PH_WDATA,
    PH_WACK,
    PH_RDATA,
    PH_RACK,
    PH_SKIP
  } phase_e;

endpackage

// File: rtl/i2c_oe_edge.sv
module i2c_oe_edge #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] level_o,
  output logic [LINES-1:0] prev_o
);

  // One synchronizer chain plus a history flop for each bus line.
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign level_o[g] = chain_q[STAGES-1];
    assign prev_o[g]  = prev_q;
  end

endmodule

// File: rtl/i2c_oe_engine.sv
module i2c_oe_engine
  import i2c_oe_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_ev,
  input  logic               stop_ev,
  input  logic [STRAP_W-1:0] strap,
  output logic [DATA_W-1:0]  mask_o,
  output logic               sda_low_o
);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] mask_q;
  logic              rw_q;
  logic              drv_q;

  logic byte_full;
  logic last_bit;
  logic addr_hit;
  logic [DATA_W-1:0] shifted;

  assign byte_full = (cnt_q == CNT_W'(DATA_W));
  assign last_bit  = (cnt_q == CNT_W'(DATA_W - 1));
  assign shifted   = {shreg_q[DATA_W-2:0], sda_s};
  assign addr_hit  = (shreg_q[DATA_W-1 -: FIXED_W] == ADDR_FIXED) &&
                     (shreg_q[STRAP_W:1] == strap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      tx_q    <= '0;
      mask_q  <= '0;
      rw_q    <= 1'b0;
      drv_q   <= 1'b0;
    end else if (start_ev) begin
      phase_q <= PH_ADDR;
      cnt_q   <= '0;
      drv_q   <= 1'b0;
    end else if (stop_ev) begin
      phase_q <= PH_IDLE;
      drv_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_ADDR: begin
          if (scl_rise && !byte_full) begin
            shreg_q <= shifted;
            cnt_q   <= cnt_q + 1'b1;
          end else if (scl_fall && byte_full) begin
            if (addr_hit) begin
              rw_q    <= shreg_q[0];
              drv_q   <= 1'b1;
              phase_q <= PH_AACK;
            end else begin
              phase_q <= PH_SKIP;
            end
          end
        end
        PH_AACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (!rw_q) begin
              drv_q   <= 1'b0;
              phase_q <= PH_WDATA;
            end else begin
              tx_q    <= mask_q;
              drv_q   <= ~mask_q[DATA_W-1];
              phase_q <= PH_RDATA;
            end
          end
        end
        PH_WDATA: begin
          if (scl_rise && !byte_full) begin
            shreg_q <= shifted;
            cnt_q   <= cnt_q + 1'b1;
            if (last_bit) mask_q <= shifted;
          end else if (scl_fall && byte_full) begin
            drv_q   <= 1'b1;
            phase_q <= PH_WACK;
          end
        end
        PH_WACK: begin
          if (scl_fall) begin
            drv_q   <= 1'b0;
            phase_q <= PH_SKIP;
          end
        end
        PH_RDATA: begin
          if (scl_fall) begin
            if (last_bit) begin
              drv_q   <= 1'b0;
              phase_q <= PH_RACK;
            end else begin
              drv_q <= ~tx_q[DATA_W-2];
              tx_q  <= tx_q << 1;
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        PH_RACK: begin
          if (scl_fall) phase_q <= PH_SKIP;
        end
        default: ;
      endcase
    end
  end

  assign mask_o    = mask_q;
  assign sda_low_o = drv_q;

  // R2
  ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_AACK || phase_q == PH_WACK) |-> drv_q);

  // R3
  mask_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(mask_q) |-> $past(phase_q == PH_WDATA && scl_rise));

  // R4
  rack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RACK) |-> !drv_q);

  // R5
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SKIP) |-> !drv_q);

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (phase_q == PH_ADDR && !drv_q && cnt_q == '0));

  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (phase_q == PH_IDLE && !drv_q));

  // R9
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(drv_q) |-> !$past(scl_s));

endmodule

// File: rtl/i2c_oe_mask_slave.sv
module i2c_oe_mask_slave
  import i2c_oe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [DATA_W-1:0]  mask_o,
  output logic               sda_low_o
);

  localparam int LN_SCL = 0;
  localparam int LN_SDA = 1;
  localparam int NLINES = 2;

  logic [NLINES-1:0] lvl;
  logic [NLINES-1:0] prv;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2c_oe_edge #(
    .LINES (NLINES),
    .STAGES(SYNC_STAGES)
  ) i_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({sda_i, scl_i}),
    .level_o(lvl),
    .prev_o (prv)
  );

  assign scl_rise = lvl[LN_SCL] & ~prv[LN_SCL];
  assign scl_fall = ~lvl[LN_SCL] & prv[LN_SCL];
  assign start_ev = lvl[LN_SCL] & prv[LN_SCL] & prv[LN_SDA] & ~lvl[LN_SDA];
  assign stop_ev  = lvl[LN_SCL] & prv[LN_SCL] & ~prv[LN_SDA] & lvl[LN_SDA];

  i2c_oe_engine i_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (lvl[LN_SCL]),
    .sda_s    (lvl[LN_SDA]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .strap    (strap_i),
    .mask_o   (mask_o),
    .sda_low_o(sda_low_o)
  );

endmodule

// File: tb/test_i2c_oe_mask_slave.sv
module test_i2c_oe_mask_slave;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [1:0] strap = 2'b10;
  logic [7:0] mask;
  logic       sda_low;
  logic       sda_line;

  assign sda_line = m_sda & ~sda_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_oe_mask_slave i_i2c_oe_mask_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (m_scl),
    .sda_i    (sda_line),
    .strap_i  (strap),
    .mask_o   (mask),
    .sda_low_o(sda_low)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference: bus history queues and an integer phase.
  localparam int M_IDLE = 0, M_ADDR = 1, M_AACK = 2, M_WDATA = 3,
                 M_WACK = 4, M_RDATA = 5, M_RACK = 6, M_SKIP = 7;
  int hc[$];
  int hd[$];
  int ph, bits, acc, rw, mmask, mdrv, tx;
  int cc, pc, cd, pd;
  bit rise, fall, st, sp;

  always @(posedge clk) begin
    if (!rst_n) begin
      hc = '{1, 1, 1};
      hd = '{1, 1, 1};
      ph = M_IDLE; bits = 0; acc = 0; rw = 0; mmask = 0; mdrv = 0; tx = 0;
    end else begin
      cc = hc[1]; pc = hc[2]; cd = hd[1]; pd = hd[2];
      rise = (cc == 1) && (pc == 0);
      fall = (cc == 0) && (pc == 1);
      st = (cc == 1) && (pc == 1) && (pd == 1) && (cd == 0);
      sp = (cc == 1) && (pc == 1) && (pd == 0) && (cd == 1);
      if (st) begin
        ph = M_ADDR; bits = 0; mdrv = 0;
      end else if (sp) begin
        ph = M_IDLE; mdrv = 0;
      end else begin
        case (ph)
          M_ADDR: begin
            if (rise) begin acc = ((acc << 1) | cd) & 255; bits++; end
            if (fall && bits == 8) begin
              if ((acc >> 3) == 26 && ((acc >> 1) & 3) == int'(strap)) begin
                rw = acc & 1; mdrv = 1; ph = M_AACK;
              end else ph = M_SKIP;
            end
          end
          M_AACK: if (fall) begin
            bits = 0;
            if (rw == 0) begin mdrv = 0; ph = M_WDATA; end
            else begin tx = mmask; mdrv = ((tx >> 7) & 1) ? 0 : 1; ph = M_RDATA; end
          end
          M_WDATA: begin
            if (rise) begin
              acc = ((acc << 1) | cd) & 255; bits++;
              if (bits == 8) mmask = acc;
            end
            if (fall && bits == 8) begin mdrv = 1; ph = M_WACK; end
          end
          M_WACK: if (fall) begin mdrv = 0; ph = M_SKIP; end
          M_RDATA: if (fall) begin
            bits++;
            if (bits == 8) begin mdrv = 0; ph = M_RACK; end
            else mdrv = ((tx >> (7 - bits)) & 1) ? 0 : 1;
          end
          M_RACK: if (fall) ph = M_SKIP;
          default: ;
        endcase
      end
      hc.push_front(int'(m_scl));
      hd.push_front(int'(sda_line));
      if (hc.size() > 4) void'(hc.pop_back());
      if (hd.size() > 4) void'(hd.pop_back());
    end
  end

  logic prev_low = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " mask vs model"}, int'(mask), mmask);
      chk({cur_req, " sda drive vs model"}, int'(sda_low), mdrv);
      if (sda_low !== prev_low) chk("R9 drive change with SCL low", int'(m_scl), 0);
    end
    prev_low = sda_low;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic seen);
    wait_clk(2);
    m_sda = b;
    wait_clk(HALF);
    m_scl = 1'b1;
    wait_clk(HALF);
    seen = sda_line;
    m_scl = 1'b0;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1;
    wait_clk(HALF);
    m_sda = 1'b0;
    wait_clk(HALF);
    m_scl = 1'b0;
  endtask

  task automatic bus_restart();
    wait_clk(2);
    m_sda = 1'b1;
    wait_clk(HALF);
    m_scl = 1'b1;
    wait_clk(HALF);
    m_sda = 1'b0;
    wait_clk(HALF);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wait_clk(2);
    m_sda = 1'b0;
    wait_clk(HALF);
    m_scl = 1'b1;
    wait_clk(HALF);
    m_sda = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    logic s;
    for (int i = 7; i > 7 - n; i--) send_bit(v[i], s);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) send_bit(v[i], s);
    send_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b1, s);
      v[i] = s;
    end
    send_bit(~master_ack, s);
    chk("R4 released during master ack bit", int'(sda_low), 0);
  endtask

  function automatic logic [7:0] adr(input logic [1:0] s, input logic r);
    return {5'b11010, s, r};
  endfunction

  logic       ak;
  logic [7:0] rd;

  initial begin
    wait_clk(5);
    chk("R1 reset mask", int'(mask), 0);
    chk("R1 reset drive", int'(sda_low), 0);
    rst_n = 1'b1;
    wait_clk(5);

    cur_req = "R3";
    bus_start();
    send_byte(adr(2'b10, 1'b0), ak); chk("R2 write address acked", int'(ak), 1);
    send_byte(8'hA5, ak);            chk("R3 data acked", int'(ak), 1);
    bus_stop();
    chk("R3 mask after write", int'(mask), 'hA5);

    cur_req = "R4";
    bus_start();
    send_byte(adr(2'b10, 1'b1), ak); chk("R2 read address acked", int'(ak), 1);
    recv_byte(1'b0, rd);             chk("R4 read value", int'(rd), 'hA5);
    bus_stop();

    cur_req = "R5";
    bus_start();
    send_byte(adr(2'b01, 1'b0), ak); chk("R5 strap mismatch no ack", int'(ak), 0);
    send_byte(8'h00, ak);            chk("R5 data ignored no ack", int'(ak), 0);
    bus_stop();
    chk("R5 mask kept", int'(mask), 'hA5);
    bus_start();
    send_byte(8'hAC, ak);            chk("R2 wrong fixed bits no ack", int'(ak), 0);
    bus_stop();

    cur_req = "R7";
    bus_start();
    send_byte(adr(2'b10, 1'b0), ak); chk("R7 address acked", int'(ak), 1);
    send_bits(8'h00, 4);
    bus_stop();
    chk("R7 partial write discarded", int'(mask), 'hA5);

    cur_req = "R6";
    bus_start();
    send_byte(adr(2'b10, 1'b0), ak);
    send_bits(8'h00, 3);
    bus_restart();
    send_byte(adr(2'b10, 1'b0), ak); chk("R6 address after restart acked", int'(ak), 1);
    send_byte(8'h3C, ak);
    bus_stop();
    chk("R6 mask after restart write", int'(mask), 'h3C);
    bus_start();
    send_bits(adr(2'b10, 1'b0), 4);
    bus_restart();
    send_byte(adr(2'b10, 1'b1), ak); chk("R6 read after mid-address restart", int'(ak), 1);
    recv_byte(1'b0, rd);             chk("R6 read value", int'(rd), 'h3C);
    bus_stop();

    cur_req = "R8";
    bus_start();
    send_byte(adr(2'b10, 1'b0), ak);
    send_byte(8'h81, ak);            chk("R8 first byte acked", int'(ak), 1);
    send_byte(8'hFF, ak);            chk("R8 second byte not acked", int'(ak), 0);
    bus_stop();
    chk("R8 mask keeps first byte", int'(mask), 'h81);

    cur_req = "R2";
    strap = 2'b01;
    wait_clk(4);
    bus_start();
    send_byte(adr(2'b10, 1'b0), ak); chk("R2 old strap refused", int'(ak), 0);
    bus_stop();
    bus_start();
    send_byte(adr(2'b01, 1'b0), ak); chk("R2 new strap acked", int'(ak), 1);
    send_byte(8'h00, ak);
    bus_stop();
    chk("R3 all-zero write", int'(mask), 0);
    cur_req = "R4";
    bus_start();
    send_byte(adr(2'b01, 1'b1), ak);
    recv_byte(1'b1, rd);             chk("R4 all-zero read with master ack", int'(rd), 0);
    bus_stop();
    bus_start();
    send_byte(adr(2'b01, 1'b0), ak);
    send_byte(8'hFF, ak);
    bus_restart();
    send_byte(adr(2'b01, 1'b1), ak);
    recv_byte(1'b0, rd);             chk("R4 all-ones read", int'(rd), 'hFF);
    bus_stop();
    wait_clk(10);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    done = 1'b1;
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule